// File: doc/BRIEF.md
# Dual-Edge Thermometer Transition Encoder

This block turns one clock period's worth of a tapped time sample, a 32-bit word whose bit k is the level seen at tap k, into two compact 6-bit words. One word reports where the sampled signal went from low to high. The other reports where it went from high to low. Each word carries a hit flag and a 5-bit tap position. Bit 0 of the following period's sample is supplied next to the current sample, so a transition that falls between the last tap and the first tap of the next period is still found.

When several transitions of the same kind are present, the one with the lowest tap index is reported. When there is none, the hit flag is clear and the position field still tells whether the first tap was low or high. A reader can therefore tell an all-low period from an all-high one. The words are registered, and a valid strobe marks each new pair.

Top module: `edge_pair_encoder`

## Requirements
- R1: While rst is high and in the first cycle after it, out_valid is 0 and both out_rise and out_fall are 6'h00.
- R2: out_valid is high in the cycle after each clock edge that sampled in_valid high, and low after an edge that sampled in_valid low.
- R3: Each output word carries the hit flag in bit 5 and the tap position in bits [4:0]. out_rise has hit=1 and position i when i is the lowest index with tap i low and tap i+1 high.
- R4: Tap 32 is in_next_bit0, so position 31 reports a transition between in_sample[31] and in_next_bit0.
- R5: With no low-to-high transition, out_rise is hit=0 with position equal to in_sample[0]: 0 for an all-low sample, 1 when tap 0 is high.
- R6: out_fall has hit=1 and position i when i is the lowest index with tap i high and tap i+1 low, again using in_next_bit0 as tap 32.
- R7: With no high-to-low transition, out_fall is hit=0 with position equal to the inverse of in_sample[0]: 0 for an all-high sample, 1 when tap 0 is low.
- R8: Taps above the first transition of a kind do not change that word, even when they hold further transitions of the same kind.
- R9: An edge that samples in_valid low leaves out_rise and out_fall unchanged, whatever in_sample and in_next_bit0 hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample is valid this cycle |
| in_sample | input | 32 | Tap levels for the current period, bit k = tap k |
| in_next_bit0 | input | 1 | Tap 0 of the following period |
| out_valid | output | 1 | New word pair present |
| out_rise | output | 6 | Low-to-high word: [5] hit, [4:0] position |
| out_fall | output | 6 | High-to-low word: [5] hit, [4:0] position |

## Verification
The bench places a single edge at every tap position for both polarities, including the wrap position 31 where only in_next_bit0 completes the edge. A design that ignored the next-period bit would report no hit there, and one off by one would report 30 or 0. The all-low, all-high and tap-0-only cases drive the fallback field, where swapping the polarity of the fallback gives 0 and 1 the wrong way round. Samples with several edges catch an encoder that keeps the highest index instead of the lowest. A random sweep is compared against a linear-scan model, and idle cycles with changing inputs show whether the registers wrongly load while in_valid is low.

// File: rtl/edge_pair_pkg.sv
package edge_pair_pkg;

    localparam int SAMPLE_W = 32;
    localparam int POS_W    = $clog2(SAMPLE_W);
    localparam int WORD_W   = POS_W + 1;

    typedef enum logic {
        POL_RISE = 1'b0,
        POL_FALL = 1'b1
    } edge_pol_e;

    typedef struct packed {
        logic             hit;
        logic [POS_W-1:0] pos;
    } edge_word_t;

    function automatic edge_word_t make_miss(input logic level_flag);
        edge_word_t w;
        w.hit = 1'b0;
        w.pos = {{(POS_W-1){1'b0}}, level_flag};
        return w;
    endfunction

endpackage

// File: rtl/transition_detect.sv
module transition_detect
    import edge_pair_pkg::*;
#(
    parameter int        TAPS = SAMPLE_W,
    parameter edge_pol_e POL  = POL_RISE
) (
    input  logic [TAPS-1:0] taps,
    input  logic            tap_after,
    output logic [TAPS-1:0] marks
);
    logic [TAPS:0] ext;
    assign ext = {tap_after, taps};

    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        if (POL == POL_RISE) begin : g_rise
            assign marks[i] = ~ext[i] & ext[i+1];
        end else begin : g_fall
            assign marks[i] = ext[i] & ~ext[i+1];
        end
    end
endmodule

// File: rtl/first_hit_encoder.sv
module first_hit_encoder
    import edge_pair_pkg::*;
#(
    parameter int TAPS = SAMPLE_W
) (
    input  logic [TAPS-1:0] marks,
    input  logic            level_flag,
    output edge_word_t      word
);
    localparam int PW = $clog2(TAPS);

    always_comb begin
        word = make_miss(level_flag);
        for (int i = TAPS - 1; i >= 0; i--) begin
            if (marks[i]) begin
                word.hit = 1'b1;
                word.pos = PW'(i);
            end
        end
    end
endmodule

// File: rtl/edge_pair_encoder.sv
module edge_pair_encoder
    import edge_pair_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic                in_next_bit0,
    output logic                out_valid,
    output logic [WORD_W-1:0]   out_rise,
    output logic [WORD_W-1:0]   out_fall
);
    logic [SAMPLE_W-1:0] rise_marks;
    logic [SAMPLE_W-1:0] fall_marks;
    edge_word_t          rise_w, fall_w;
    edge_word_t          rise_q, fall_q;
    logic                valid_q;

    transition_detect #(.TAPS(SAMPLE_W), .POL(POL_RISE)) u_rise_det (
        .taps      (in_sample),
        .tap_after (in_next_bit0),
        .marks     (rise_marks)
    );

    transition_detect #(.TAPS(SAMPLE_W), .POL(POL_FALL)) u_fall_det (
        .taps      (in_sample),
        .tap_after (in_next_bit0),
        .marks     (fall_marks)
    );

    first_hit_encoder #(.TAPS(SAMPLE_W)) u_rise_enc (
        .marks      (rise_marks),
        .level_flag (in_sample[0]),
        .word       (rise_w)
    );

    first_hit_encoder #(.TAPS(SAMPLE_W)) u_fall_enc (
        .marks      (fall_marks),
        .level_flag (~in_sample[0]),
        .word       (fall_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            rise_q  <= '0;
            fall_q  <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                rise_q <= rise_w;
                fall_q <= fall_w;
            end
        end
    end

    assign out_valid = valid_q;
    assign out_rise  = rise_q;
    assign out_fall  = fall_q;
endmodule

// File: rtl/edge_pair_encoder_chk.sv
module edge_pair_encoder_chk
    import edge_pair_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [SAMPLE_W-1:0] in_sample,
    input logic                in_next_bit0,
    input logic                out_valid,
    input logic [WORD_W-1:0]   out_rise,
    input logic [WORD_W-1:0]   out_fall
);
    logic                armed;
    logic [SAMPLE_W:0]   ext_q;
    logic                vld_q;

    always_ff @(posedge clk) begin
        armed <= !rst;
        ext_q <= {in_next_bit0, in_sample};
        vld_q <= in_valid;
    end

    logic [POS_W:0] rise_nxt, fall_nxt;
    assign rise_nxt = {1'b0, out_rise[POS_W-1:0]} + 1'b1;
    assign fall_nxt = {1'b0, out_fall[POS_W-1:0]} + 1'b1;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && out_rise == '0 && out_fall == '0)); // R1

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        armed |-> (out_valid == vld_q)); // R2

    AST_RISE_HIT_EDGE: assert property (@(posedge clk) disable iff (rst)
        (armed && vld_q && out_rise[WORD_W-1]) |->
            (!ext_q[out_rise[POS_W-1:0]] && ext_q[rise_nxt])); // R3

    AST_FALL_HIT_EDGE: assert property (@(posedge clk) disable iff (rst)
        (armed && vld_q && out_fall[WORD_W-1]) |->
            (ext_q[out_fall[POS_W-1:0]] && !ext_q[fall_nxt])); // R6

    AST_RISE_MISS_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (armed && vld_q && !out_rise[WORD_W-1]) |->
            (out_rise[POS_W-1:0] == {{(POS_W-1){1'b0}}, ext_q[0]})); // R5

    AST_FALL_MISS_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (armed && vld_q && !out_fall[WORD_W-1]) |->
            (out_fall[POS_W-1:0] == {{(POS_W-1){1'b0}}, !ext_q[0]})); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (armed && !in_valid) |=> ($stable(out_rise) && $stable(out_fall))); // R9
endmodule

bind edge_pair_encoder edge_pair_encoder_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_sample    (in_sample),
    .in_next_bit0 (in_next_bit0),
    .out_valid    (out_valid),
    .out_rise     (out_rise),
    .out_fall     (out_fall)
);

// File: tb/edge_pair_encoder_tb_top.sv
module edge_pair_encoder_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] in_sample;
    logic        in_next_bit0;
    logic        out_valid;
    logic [5:0]  out_rise;
    logic [5:0]  out_fall;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    edge_pair_encoder dut_i (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_sample    (in_sample),
        .in_next_bit0 (in_next_bit0),
        .out_valid    (out_valid),
        .out_rise     (out_rise),
        .out_fall     (out_fall)
    );

    function automatic logic [5:0] model(input logic [31:0] s, input logic n0, input bit fall);
        logic [32:0] e;
        e = {n0, s};
        for (int i = 0; i < 32; i++) begin
            if (!fall && !e[i] && e[i+1]) return {1'b1, 5'(i)};
            if (fall && e[i] && !e[i+1])  return {1'b1, 5'(i)};
        end
        return fall ? {5'b0, ~s[0]} : {5'b0, s[0]};
    endfunction

    task automatic check6(input string req, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // drive at negedge, result registered at the next posedge, sample 2 ns later
    task automatic apply(input logic [31:0] s, input logic n0, input logic v);
        @(negedge clk);
        in_sample    = s;
        in_next_bit0 = n0;
        in_valid     = v;
        @(posedge clk);
        #2;
    endtask

    task automatic apply_check(input string req, input logic [31:0] s, input logic n0);
        apply(s, n0, 1'b1);
        check6({req, " rise"}, out_rise, model(s, n0, 1'b0));
        check6({req, " fall"}, out_fall, model(s, n0, 1'b1));
        check1({req, " valid"}, out_valid, 1'b1);
    endtask

    task automatic t_reset;
        rst = 1'b1; in_valid = 1'b0; in_sample = '1; in_next_bit0 = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check1("R1 valid", out_valid, 1'b0);
        check6("R1 rise", out_rise, 6'h00);
        check6("R1 fall", out_fall, 6'h00);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #2;
        check1("R1 valid after", out_valid, 1'b0);
        check6("R1 rise after", out_rise, 6'h00);
    endtask

    task automatic t_single_edges;
        for (int i = 0; i < 31; i++) begin
            logic [31:0] s;
            s = ~((32'd1 << (i + 1)) - 32'd1);        // zeros at 0..i, ones above
            apply(s, 1'b1, 1'b1);
            check6("R3 rise position", out_rise, {1'b1, 5'(i)});
            apply(~s, 1'b0, 1'b1);
            check6("R6 fall position", out_fall, {1'b1, 5'(i)});
        end
    endtask

    task automatic t_wrap;
        apply(32'h0000_0000, 1'b1, 1'b1);
        check6("R4 rise wrap", out_rise, 6'h3F);
        check6("R4 fall none", out_fall, 6'h01);
        apply(32'hFFFF_FFFF, 1'b0, 1'b1);
        check6("R4 fall wrap", out_fall, 6'h3F);
        check6("R4 rise none", out_rise, 6'h01);
    endtask

    task automatic t_fallback;
        apply(32'h0000_0000, 1'b0, 1'b1);
        check6("R5 all low rise", out_rise, 6'h00);
        check6("R7 all low fall", out_fall, 6'h01);
        apply(32'hFFFF_FFFF, 1'b1, 1'b1);
        check6("R5 all high rise", out_rise, 6'h01);
        check6("R7 all high fall", out_fall, 6'h00);
        apply(32'h0000_00FF, 1'b0, 1'b1);
        check6("R5 tap0 high no rise", out_rise, 6'h01);
        check6("R6 fall at 7", out_fall, 6'h27);
        apply(32'hFFFF_0000, 1'b1, 1'b1);
        check6("R7 tap0 low no fall", out_fall, 6'h01);
        check6("R3 rise at 15", out_rise, 6'h2F);
    endtask

    task automatic t_priority;
        apply(32'hA5A5_0F04, 1'b0, 1'b1);       // rises at 1,7,..., falls at 2,...
        check6("R8 rise lowest", out_rise, 6'h21);
        check6("R8 fall lowest", out_fall, 6'h22);
        apply(32'h5555_5554, 1'b1, 1'b1);
        check6("R8 rise lowest alt", out_rise, 6'h21);
        check6("R8 fall lowest alt", out_fall, 6'h22);
    endtask

    task automatic t_hold;
        apply(32'h0000_0010, 1'b0, 1'b1);
        apply(32'hFFFF_FFF0, 1'b1, 1'b0);
        check1("R2 valid low", out_valid, 1'b0);
        check6("R9 rise held", out_rise, 6'h23);
        check6("R9 fall held", out_fall, 6'h24);
        apply(32'h1234_5678, 1'b0, 1'b0);
        check6("R9 rise held again", out_rise, 6'h23);
        check6("R9 fall held again", out_fall, 6'h24);
        apply(32'h0000_0100, 1'b0, 1'b1);
        check1("R2 valid back", out_valid, 1'b1);
        check6("R3 rise reload", out_rise, 6'h27);
    endtask

    task automatic t_random;
        for (int k = 0; k < 400; k++) begin
            logic [31:0] s;
            logic [31:0] r;
            r = $urandom;
            s = $urandom;
            if (r[2:0] == 3'd0) s = s & (32'hFFFF_FFFF << r[8:4]);
            apply_check("R3 R6 random", s, r[31]);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_single_edges();
        t_wrap();
        t_fallback();
        t_priority();
        t_hold();
        t_random();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule